// File: doc/BRIEF.md
# Instruction-Sequenced Matrix-Vector Multiply Engine

This engine multiplies a stream of input-vector chunks by a weight matrix that it holds locally. It has `NUM_DPE` dot-product units. Each unit is `LANES` lanes wide and owns a private weight register file and a private accumulator memory. In each step, every unit multiplies the head chunk of the input FIFO by one of its weight rows. The engine then combines that product with the accumulator entry, optionally adds one element of a partial-sum vector taken from the reduction FIFO, and writes the sum back to the accumulator.

A small program of 32-bit micro-instructions, one per chunk, sequences the engine. Each instruction chooses the weight row, the accumulator entry, and four controls: accumulate, reduce, release and last. A released step pushes all unit results, tagged with a destination and a kind, into an output FIFO. The program counter wraps from the last programmed instruction back to the first on its own, so a single load serves an endless stream of input vectors.

The instruction fields, from MSB to LSB:
- `kind` is bit 31.
- `dest` is bits 30:22.
- `row` is bits 21:13.
- `slot` is bits 12:4.
- `last` is bit 3.
- `release` is bit 2.
- `accumulate` is bit 1.
- `reduce` is bit 0.

Top module: `mvm_engine`

## Requirements
- R1: For each unit u, a step computes the signed sum over lanes l of `chunk[8l+:8] * weight_u[row][8l+:8]`. Operands are signed 8-bit and results are signed 32-bit. The result of unit u appears on bits `[32u+:32]` of the result vector.
- R2: With `accumulate` (bit 1) at 0, the step ignores the old contents of accumulator entry `slot` and overwrites them. With it at 1, the stored value is added to the dot product and the sum is written back.
- R3: With `reduce` (bit 0) at 1, the step adds element u (bits `[32u+:32]`) of the head of the reduction FIFO to unit u's result and pops that entry.
- R4: With `release` (bit 2) at 1, the step pushes one output entry holding the result vector, `dest` (bits 30:22), `kind` (bit 31) and `last` (bit 3). With `release` at 0, the step pushes nothing.
- R5: `row` (bits 21:13) selects the weight row and `slot` (bits 12:4) selects the accumulator entry. In each unit, the address is taken modulo the depth of that memory.
- R6: After the instruction at index `prog_len_i-1` issues, the next instruction is index 0. When `prog_len_i` is 0, no instruction issues.
- R7: An instruction issues only when all of its needs are met: an input chunk is queued, a reduction entry is queued if `reduce` is set, and the output FIFO has room if `release` is set. Otherwise the engine waits, and the program counter and all queues keep their contents.
- R8: Each issued instruction consumes exactly one chunk. Chunks are consumed in arrival order and results leave in issue order.
- R9: While `res_valid_o` is high and `res_ready_i` is low, the output entry stays unchanged.
- R10: After reset, `res_valid_o` is 0, `chunk_ready_o` and `red_ready_o` are 1, and the program counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wgt_we_i | input | 1 | Weight row write strobe |
| wgt_unit_i | input | UNIT_W | Unit whose register file is written |
| wgt_addr_i | input | RF_AW | Weight row address |
| wgt_row_i | input | LANES*8 | Weight row, lane l at bits 8l+:8 |
| prog_we_i | input | 1 | Instruction write strobe |
| prog_addr_i | input | PC_AW | Instruction index |
| prog_data_i | input | 32 | Instruction word |
| prog_len_i | input | LEN_W | Number of active instructions, 0 halts |
| chunk_valid_i | input | 1 | Push input chunk |
| chunk_data_i | input | LANES*8 | Input chunk, lane l at bits 8l+:8 |
| chunk_ready_o | output | 1 | Input FIFO not full |
| red_valid_i | input | 1 | Push reduction vector |
| red_data_i | input | NUM_DPE*32 | Partial-sum vector |
| red_ready_o | output | 1 | Reduction FIFO not full |
| res_valid_o | output | 1 | Output FIFO not empty |
| res_data_o | output | NUM_DPE*32 | Result vector at head |
| res_dest_o | output | 9 | Destination tag at head |
| res_op_o | output | 1 | Kind tag at head (0 partial sum, 1 input vector) |
| res_last_o | output | 1 | Last flag at head |
| res_ready_i | input | 1 | Pop output entry |

## Verification
The hardest case to reach is a release step that finds the output FIFO full while chunks are still waiting. Only then can a lost or doubled chunk show up. The bench holds `res_ready_i` low and pushes more chunks than the output FIFO holds, until the input queue also reports full. It then drains the queues and checks every result in order. A second hard case is a reduce step that is blocked only by a missing partial-sum vector. The bench loads a three-step accumulate program, queues all three chunks without a reduction vector, and checks that no result appears until the vector arrives. It then checks that a second pass through the looped program overwrites, rather than extends, the accumulator entry.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
  localparam int OPND_W = 8;
  localparam int ACC_W  = 32;
  localparam int TAG_W  = 9;

  typedef struct packed {
    logic             kind;
    logic [TAG_W-1:0] dest;
    logic [8:0]       row;
    logic [8:0]       slot;
    logic             last;
    logic             rls;
    logic             acm;
    logic             rdc;
  } instr_t;
endpackage

// File: rtl/mvm_fifo.sv
module mvm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mvm_dpe.sv
module mvm_dpe
  import mvm_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int RF_DEPTH  = 16,
  parameter int ACC_DEPTH = 16,
  localparam int RF_AW    = $clog2(RF_DEPTH),
  localparam int ACC_AW   = $clog2(ACC_DEPTH),
  localparam int CHUNK_W  = LANES * OPND_W
) (
  input  logic               clk_i,
  input  logic               wr_en_i,
  input  logic [RF_AW-1:0]   wr_addr_i,
  input  logic [CHUNK_W-1:0] wr_row_i,
  input  logic [RF_AW-1:0]   row_i,
  input  logic [ACC_AW-1:0]  slot_i,
  input  logic [CHUNK_W-1:0] chunk_i,
  input  logic               acm_i,
  input  logic               rdc_i,
  input  logic [ACC_W-1:0]   red_i,
  input  logic               fire_i,
  output logic [ACC_W-1:0]   result_o
);
  logic [CHUNK_W-1:0] rf_q  [RF_DEPTH];
  logic [ACC_W-1:0]   acc_q [ACC_DEPTH];
  logic [CHUNK_W-1:0] w_row;
  logic signed [ACC_W-1:0] dot;

  assign w_row = rf_q[row_i];

  always_comb begin
    dot = '0;
    for (int l = 0; l < LANES; l++) begin
      logic signed [2*OPND_W-1:0] prod;
      prod = $signed(w_row[l*OPND_W +: OPND_W]) * $signed(chunk_i[l*OPND_W +: OPND_W]);
      dot  = dot + ACC_W'(prod);
    end
  end

  assign result_o = dot + (acm_i ? acc_q[slot_i] : '0) + (rdc_i ? red_i : '0);

  always_ff @(posedge clk_i) begin
    if (wr_en_i) rf_q[wr_addr_i] <= wr_row_i;
    if (fire_i)  acc_q[slot_i]  <= result_o;
  end
endmodule

// File: rtl/mvm_engine.sv
module mvm_engine
  import mvm_pkg::*;
#(
  parameter int NUM_DPE    = 4,
  parameter int LANES      = 4,
  parameter int RF_DEPTH   = 16,
  parameter int ACC_DEPTH  = 16,
  parameter int PROG_DEPTH = 64,
  parameter int IN_DEPTH   = 4,
  parameter int RED_DEPTH  = 2,
  parameter int OUT_DEPTH  = 2,
  localparam int UNIT_W    = (NUM_DPE > 1) ? $clog2(NUM_DPE) : 1,
  localparam int RF_AW     = $clog2(RF_DEPTH),
  localparam int ACC_AW    = $clog2(ACC_DEPTH),
  localparam int PC_AW     = $clog2(PROG_DEPTH),
  localparam int LEN_W     = $clog2(PROG_DEPTH + 1),
  localparam int CHUNK_W   = LANES * OPND_W,
  localparam int VEC_W     = NUM_DPE * ACC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wgt_we_i,
  input  logic [UNIT_W-1:0]  wgt_unit_i,
  input  logic [RF_AW-1:0]   wgt_addr_i,
  input  logic [CHUNK_W-1:0] wgt_row_i,
  input  logic               prog_we_i,
  input  logic [PC_AW-1:0]   prog_addr_i,
  input  logic [31:0]        prog_data_i,
  input  logic [LEN_W-1:0]   prog_len_i,
  input  logic               chunk_valid_i,
  input  logic [CHUNK_W-1:0] chunk_data_i,
  output logic               chunk_ready_o,
  input  logic               red_valid_i,
  input  logic [VEC_W-1:0]   red_data_i,
  output logic               red_ready_o,
  output logic               res_valid_o,
  output logic [VEC_W-1:0]   res_data_o,
  output logic [TAG_W-1:0]   res_dest_o,
  output logic               res_op_o,
  output logic               res_last_o,
  input  logic               res_ready_i
);
  localparam int OUT_W = VEC_W + TAG_W + 2;

  logic [31:0]        prog_q [PROG_DEPTH];
  logic [PC_AW-1:0]   pc_q;
  instr_t             cur;
  logic               issue;
  logic               in_empty, in_full, red_empty, red_full, out_empty, out_full;
  logic [CHUNK_W-1:0] chunk_head;
  logic [VEC_W-1:0]   red_head, res_vec;
  logic [OUT_W-1:0]   out_head;
  logic               unused_addr_bits;

  assign cur = instr_t'(prog_q[pc_q]);
  assign unused_addr_bits = ^{cur.row[8:RF_AW], cur.slot[8:ACC_AW]};

  assign issue = (prog_len_i != '0) && !in_empty
              && (!cur.rdc || !red_empty)
              && (!cur.rls || !out_full);

  always_ff @(posedge clk_i) begin
    if (prog_we_i) prog_q[prog_addr_i] <= prog_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else if (issue) begin
      if (LEN_W'(pc_q) + LEN_W'(1) >= prog_len_i) pc_q <= '0;
      else                                         pc_q <= pc_q + 1'b1;
    end
  end

  mvm_fifo #(.W(CHUNK_W), .DEPTH(IN_DEPTH)) u_in_fifo (
    .clk_i, .rst_ni,
    .push_i(chunk_valid_i), .wdata_i(chunk_data_i),
    .pop_i(issue), .rdata_o(chunk_head),
    .full_o(in_full), .empty_o(in_empty)
  );

  mvm_fifo #(.W(VEC_W), .DEPTH(RED_DEPTH)) u_red_fifo (
    .clk_i, .rst_ni,
    .push_i(red_valid_i), .wdata_i(red_data_i),
    .pop_i(issue && cur.rdc), .rdata_o(red_head),
    .full_o(red_full), .empty_o(red_empty)
  );

  for (genvar g = 0; g < NUM_DPE; g++) begin : g_dpe
    mvm_dpe #(.LANES(LANES), .RF_DEPTH(RF_DEPTH), .ACC_DEPTH(ACC_DEPTH)) u_dpe (
      .clk_i,
      .wr_en_i  (wgt_we_i && (wgt_unit_i == UNIT_W'(g))),
      .wr_addr_i(wgt_addr_i),
      .wr_row_i (wgt_row_i),
      .row_i    (cur.row[RF_AW-1:0]),
      .slot_i   (cur.slot[ACC_AW-1:0]),
      .chunk_i  (chunk_head),
      .acm_i    (cur.acm),
      .rdc_i    (cur.rdc),
      .red_i    (red_head[g*ACC_W +: ACC_W]),
      .fire_i   (issue),
      .result_o (res_vec[g*ACC_W +: ACC_W])
    );
  end

  mvm_fifo #(.W(OUT_W), .DEPTH(OUT_DEPTH)) u_out_fifo (
    .clk_i, .rst_ni,
    .push_i(issue && cur.rls),
    .wdata_i({cur.kind, cur.dest, cur.last, res_vec}),
    .pop_i(res_ready_i), .rdata_o(out_head),
    .full_o(out_full), .empty_o(out_empty)
  );

  assign chunk_ready_o = !in_full;
  assign red_ready_o   = !red_full;
  assign res_valid_o   = !out_empty;
  assign {res_op_o, res_dest_o, res_last_o, res_data_o} = out_head;
endmodule

// File: rtl/mvm_engine_chk.sv
module mvm_engine_chk #(
  parameter int PC_AW = 6,
  parameter int LEN_W = 7,
  parameter int VEC_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_i,
  input logic             in_empty_i,
  input logic             red_empty_i,
  input logic             out_full_i,
  input logic             rdc_i,
  input logic             rls_i,
  input logic [PC_AW-1:0] pc_i,
  input logic [LEN_W-1:0] len_i,
  input logic             res_valid_i,
  input logic             res_ready_i,
  input logic [VEC_W-1:0] res_data_i
);
  AST_ISSUE_HAS_CHUNK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !in_empty_i); // R7
  AST_REDUCE_HAS_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && rdc_i |-> !red_empty_i); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && rls_i |-> !out_full_i); // R4
  AST_PC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && (LEN_W'(pc_i) + LEN_W'(1) >= len_i) |=> pc_i == '0); // R6
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && (LEN_W'(pc_i) + LEN_W'(1) < len_i) |=> pc_i == $past(pc_i) + 1'b1); // R6
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(pc_i)); // R7
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !res_ready_i |=> res_valid_i && $stable(res_data_i)); // R9
endmodule

bind mvm_engine mvm_engine_chk #(.PC_AW(PC_AW), .LEN_W(LEN_W), .VEC_W(VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(issue),
  .in_empty_i(in_empty), .red_empty_i(red_empty), .out_full_i(out_full),
  .rdc_i(cur.rdc), .rls_i(cur.rls), .pc_i(pc_q), .len_i(prog_len_i),
  .res_valid_i(res_valid_o), .res_ready_i(res_ready_i), .res_data_i(res_data_o)
);

// File: tb/tb_mvm_engine.sv
module tb_mvm_engine;
  localparam int D = 4;
  localparam int L = 4;
  localparam int NV = 6;
  localparam logic [31:0] VEC_CHUNK [NV] = '{32'h01020304, 32'hFF7F8001, 32'h80808080,
                                            32'h00000000, 32'h7F7F7F7F, 32'h10F0203C};
  localparam logic [3:0]  VEC_ROW   [NV] = '{4'd0, 4'd3, 4'd7, 4'd5, 4'd7, 4'd6};

  logic clk = 0, rst_ni = 0;
  logic wgt_we = 0; logic [1:0] wgt_unit = 0; logic [3:0] wgt_addr = 0; logic [31:0] wgt_row = 0;
  logic prog_we = 0; logic [5:0] prog_addr = 0; logic [31:0] prog_data = 0; logic [6:0] prog_len = 0;
  logic chunk_valid = 0; logic [31:0] chunk_data = 0; logic chunk_ready;
  logic red_valid = 0; logic [127:0] red_data = 0; logic red_ready;
  logic res_valid, res_op, res_last, res_ready = 0;
  logic [127:0] res_data; logic [8:0] res_dest;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mvm_engine dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wgt_we_i(wgt_we), .wgt_unit_i(wgt_unit), .wgt_addr_i(wgt_addr), .wgt_row_i(wgt_row),
    .prog_we_i(prog_we), .prog_addr_i(prog_addr), .prog_data_i(prog_data), .prog_len_i(prog_len),
    .chunk_valid_i(chunk_valid), .chunk_data_i(chunk_data), .chunk_ready_o(chunk_ready),
    .red_valid_i(red_valid), .red_data_i(red_data), .red_ready_o(red_ready),
    .res_valid_o(res_valid), .res_data_o(res_data), .res_dest_o(res_dest),
    .res_op_o(res_op), .res_last_o(res_last), .res_ready_i(res_ready)
  );

  function automatic logic [7:0] wgt(int u, int r, int l);
    if (r == 7) return 8'h80;
    return 8'(u*29 + r*13 + l*7 + 3 - 90);
  endfunction

  function automatic int dotp(int u, int r, logic [31:0] c);
    int s = 0;
    for (int l = 0; l < L; l++) s += int'($signed(wgt(u, r, l))) * int'($signed(c[8*l +: 8]));
    return s;
  endfunction

  function automatic logic [127:0] dotv(int r, logic [31:0] c);
    logic [127:0] v;
    for (int u = 0; u < D; u++) v[32*u +: 32] = dotp(u, r, c);
    return v;
  endfunction

  function automatic logic [31:0] mk(logic op, logic [8:0] dest, logic [8:0] row, logic [8:0] slot,
                                     logic lst, logic rls, logic acm, logic rdc);
    return {op, dest, row, slot, lst, rls, acm, rdc};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_instr(int a, logic [31:0] d);
    @(negedge clk); prog_we = 1; prog_addr = 6'(a); prog_data = d;
    @(negedge clk); prog_we = 0;
  endtask

  task automatic push_chunk(logic [31:0] d);
    @(negedge clk); chunk_valid = 1; chunk_data = d;
    @(negedge clk); chunk_valid = 0;
  endtask

  task automatic push_red(logic [127:0] d);
    @(negedge clk); red_valid = 1; red_data = d;
    @(negedge clk); red_valid = 0;
  endtask

  task automatic wait_res(string req);
    int n = 0;
    while (!res_valid && n < 50) begin @(negedge clk); n++; end
    check({req, " result arrives"}, 128'(res_valid), 128'd1);
  endtask

  task automatic pop_check(string req, logic [127:0] v, logic [8:0] dest, logic op, logic lst);
    wait_res(req);
    check({req, " data"}, res_data, v);
    check({req, " tag"}, {117'd0, res_dest, res_op, res_last}, {117'd0, dest, op, lst});
    res_ready = 1; @(negedge clk); res_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] rv, rv2, exp;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 res_valid", 128'(res_valid), 128'd0);
    check("R10 chunk_ready", 128'(chunk_ready), 128'd1);
    check("R10 red_ready", 128'(red_ready), 128'd1);
    rst_ni = 1;
    @(negedge clk);
    for (int u = 0; u < D; u++)
      for (int r = 0; r < 8; r++) begin
        wgt_we = 1; wgt_unit = 2'(u); wgt_addr = 4'(r);
        for (int l = 0; l < L; l++) wgt_row[8*l +: 8] = wgt(u, r, l);
        @(negedge clk);
      end
    wgt_we = 0;

    // R1 R4 R5: table of chunks and weight rows, one release per chunk
    for (int e = 0; e < NV; e++) begin
      prog_len = 0;
      write_instr(0, mk(e[0], 9'(3*e + 1), {5'd0, VEC_ROW[e]}, 9'(e), 1'b1, 1'b1, 1'b0, 1'b0));
      prog_len = 1;
      push_chunk(VEC_CHUNK[e]);
      pop_check("R1 R5 table", dotv(int'(VEC_ROW[e]), VEC_CHUNK[e]), 9'(3*e + 1), e[0], 1'b1);
    end

    // R2 R3 R6 R7: three-step accumulate, reduce on the last step
    prog_len = 0;
    write_instr(0, mk(1'b0, 9'd0, 9'd1, 9'd2, 1'b0, 1'b0, 1'b0, 1'b0));
    write_instr(1, mk(1'b0, 9'd0, 9'd2, 9'd2, 1'b0, 1'b0, 1'b1, 1'b0));
    write_instr(2, mk(1'b0, 9'd5, 9'd3, 9'd2, 1'b1, 1'b1, 1'b1, 1'b1));
    prog_len = 3;
    for (int u = 0; u < D; u++) rv[32*u +: 32] = 1000*(u+1) - 2500;
    push_chunk(32'h05FB0A01); push_chunk(32'h807F0102); push_chunk(32'hF0E0D0C0);
    repeat (6) @(negedge clk);
    check("R7 stall without reduction vector", 128'(res_valid), 128'd0);
    push_red(rv);
    exp = '0;
    for (int u = 0; u < D; u++)
      exp[32*u +: 32] = dotp(u, 1, 32'h05FB0A01) + dotp(u, 2, 32'h807F0102)
                      + dotp(u, 3, 32'hF0E0D0C0) + int'($signed(rv[32*u +: 32]));
    pop_check("R2 R3 accumulate+reduce", exp, 9'd5, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check("R4 no push without release", 128'(res_valid), 128'd0);
    // second pass: wrap to instruction 0 must overwrite slot 2
    for (int u = 0; u < D; u++) rv2[32*u +: 32] = 7 - u;
    push_chunk(32'h01010101); push_chunk(32'h02020202); push_chunk(32'hFFFFFFFF);
    push_red(rv2);
    for (int u = 0; u < D; u++)
      exp[32*u +: 32] = dotp(u, 1, 32'h01010101) + dotp(u, 2, 32'h02020202)
                      + dotp(u, 3, 32'hFFFFFFFF) + 7 - u;
    pop_check("R6 R2 wrap overwrites", exp, 9'd5, 1'b0, 1'b1);

    // R7 R8 R9: backpressure on a full output queue
    prog_len = 0;
    write_instr(0, mk(1'b1, 9'd9, 9'd4, 9'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    prog_len = 1;
    for (int k = 0; k < 6; k++) push_chunk(32'h11111111 * (k + 1));
    repeat (4) @(negedge clk);
    check("R7 input queue full while output full", 128'(chunk_ready), 128'd0);
    rv = res_data;
    repeat (3) @(negedge clk);
    check("R9 head held", res_data, rv);
    for (int k = 0; k < 6; k++)
      pop_check("R8 order", dotv(4, 32'h11111111 * (k + 1)), 9'd9, 1'b1, 1'b0);

    // R6 halt with zero length
    prog_len = 0;
    push_chunk(32'h0A0B0C0D);
    repeat (6) @(negedge clk);
    check("R6 halted", 128'(res_valid), 128'd0);
    prog_len = 1;
    pop_check("R6 resume", dotv(4, 32'h0A0B0C0D), 9'd9, 1'b1, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule